// File: doc/BRIEF.md
# Square-Root Carry-Select Prefix Adder

This block is a purely combinational binary adder. It takes two operands and a carry-in and returns their sum and carry-out. The word is split into groups whose widths grow from the least significant end. The default 16-bit build uses groups of 2, 2, 3, 4 and 5 bits. A 32-bit build uses 2, 2, 3, 4, 5, 6, 7 and 3 bits. The split is given as a parameter table, and the widths in it must add up to the word width.

The lowest group is a small logarithmic prefix adder that takes the external carry-in directly. Each higher group works the same way in three steps:
- A minimum-node prefix adder adds the group's slice with an implied carry-in of zero. This gives an N+1 bit candidate: the sum bits plus the group carry.
- An increment converter derives the carry-in-one candidate from that result. Bit i of the converter output is the input bit XOR the AND of all lower input bits.
- A 2:1 selector picks one of the two candidates, using the carry that leaves the group below. The top bit of the chosen candidate is this group's carry-out.

The block fits wherever a short, area-lean adder is needed: address generation, accumulators and ALU datapaths. It has no clock and holds no state.

Top module: `sqrt_csel_adder`

## Requirements
- R1: `sum` equals (`op_a` + `op_b` + `carry_in`) modulo 2^WIDTH, and `carry_out` is the bit that leaves position WIDTH-1, for every input combination.
- R2: The group table is read least-significant group first, one 8-bit field per group (field g at bits [8g+7:8g]). Both the default 16-bit split {2,2,3,4,5} and the 32-bit split {2,2,3,4,5,6,7,3} produce the R1 result.
- R3: The carry that selects a group's result equals the arithmetic carry out of all bits below that group, including `carry_in`.
- R4: The carry-in-one candidate of each upper group equals its carry-in-zero candidate plus one, modulo 2^(N+1). A group whose slice sums to all ones therefore outputs all zeros and carries out when its carry-in is set.
- R5: The carry-in-zero candidate of each upper group equals the plain sum of its two operand slices, and it does not depend on `carry_in`.
- R6: `carry_in` feeds only the lowest group: raising it from 0 to 1 increases the full {`carry_out`,`sum`} value by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum modulo 2^WIDTH |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The bench aims carries at every group boundary. It adds an all-ones lower part to one, with `carry_in` both clear and set:
- A wrong selector polarity, or a misrouted group carry, leaves a stale candidate in the upper group.
- An increment converter that misses its top bit drops the group carry.

All-zeros, all-ones and alternating patterns check the prefix tree. A prefix tree with a missing down-sweep cell corrupts odd-position sums in the wider groups. Paired evaluations with `carry_in` 0 and 1 expose a carry-in that reaches anything other than the lowest group. Long random runs on both the 16-bit and the 32-bit configurations catch partition-table offsets that are off by one.

// File: rtl/csel_pkg.sv
package csel_pkg;

  typedef struct packed {
    logic p;
    logic g;
  } pg_t;

  // full combine: both group propagate and group generate
  function automatic pg_t pg_black(pg_t hi, pg_t lo);
    pg_t r;
    r.p = hi.p & lo.p;
    r.g = hi.g | (hi.p & lo.g);
    return r;
  endfunction

  // generate-only combine
  function automatic logic pg_gray(pg_t hi, logic lo_g);
    return hi.g | (hi.p & lo_g);
  endfunction

  function automatic int unsigned grp_width(bit [255:0] tbl, int unsigned g);
    return int'(tbl[g*8 +: 8]);
  endfunction

  function automatic int unsigned grp_lo(bit [255:0] tbl, int unsigned g);
    int unsigned acc;
    acc = 0;
    for (int unsigned k = 0; k < g; k++) acc += int'(tbl[k*8 +: 8]);
    return acc;
  endfunction

  function automatic int unsigned pow2_ceil(int unsigned v);
    int unsigned r;
    r = 1;
    while (r < v) r = r * 2;
    return r;
  endfunction

endpackage

// File: rtl/bk_group_adder.sv
module bk_group_adder #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);
  import csel_pkg::*;

  // node 0 carries cin as a pure generate; node i+1 is bit i
  localparam int unsigned NODES = W + 1;
  localparam int unsigned TOPD  = pow2_ceil(NODES);

  logic [W-1:0] p_bit;
  pg_t  node [NODES];

  always_comb begin
    p_bit = a ^ b;
    node[0].p = 1'b0;
    node[0].g = cin;
    for (int i = 0; i < int'(W); i++) begin
      node[i+1].p = a[i] ^ b[i];
      node[i+1].g = a[i] & b[i];
    end
    // up-sweep at power-of-two spans
    for (int d = 1; d < int'(NODES); d = d * 2) begin
      for (int i = 2*d - 1; i < int'(NODES); i = i + 2*d) begin
        node[i] = pg_black(node[i], node[i-d]);
      end
    end
    // down-sweep fills the remaining prefixes
    for (int d = int'(TOPD); d >= 1; d = d / 2) begin
      for (int i = 3*d - 1; i < int'(NODES); i = i + 2*d) begin
        node[i].g = pg_gray(node[i], node[i-d].g);
        node[i].p = node[i].p & node[i-d].p;
      end
    end
    for (int i = 0; i < int'(W); i++) s[i] = p_bit[i] ^ node[i].g;
    cout = node[W].g;
  end
endmodule

// File: rtl/add_one_conv.sv
module add_one_conv #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  logic [W-1:0] run_and;

  assign run_and[0] = 1'b1;
  assign y[0]       = ~x[0];

  for (genvar i = 1; i < W; i++) begin : g_bit
    assign run_and[i] = run_and[i-1] & x[i-1];
    assign y[i]       = x[i] ^ run_and[i];
  end
endmodule

// File: rtl/group_select.sv
module group_select #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] cand0,
  input  logic [W-1:0] cand1,
  input  logic         sel,
  output logic [W-1:0] pick
);
  assign pick = sel ? cand1 : cand0;
endmodule

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder #(
  parameter int unsigned WIDTH   = 16,
  parameter int unsigned NGROUPS = 5,
  parameter bit [NGROUPS*8-1:0] GROUP_TBL = {8'd5, 8'd4, 8'd3, 8'd2, 8'd2}
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);
  import csel_pkg::*;

  localparam bit [255:0] TBL = 256'(GROUP_TBL);

  // observable internal events
  logic [NGROUPS:0]   bnd_carry;   // carry entering each group, last = carry_out
  logic [WIDTH-1:0]   cand0_sum;
  logic [NGROUPS-1:0] cand0_c;
  logic [WIDTH-1:0]   cand1_sum;
  logic [NGROUPS-1:0] cand1_c;

  assign bnd_carry[0] = carry_in;

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    localparam int unsigned LO = grp_lo(TBL, g);
    localparam int unsigned N  = grp_width(TBL, g);

    if (g == 0) begin : g_base
      logic [N-1:0] s_l;
      logic         c_l;
      bk_group_adder #(.W(N)) u_add (
        .a(op_a[LO +: N]), .b(op_b[LO +: N]), .cin(carry_in),
        .s(s_l), .cout(c_l)
      );
      assign sum[LO +: N]       = s_l;
      assign bnd_carry[g+1]     = c_l;
      assign cand0_sum[LO +: N] = s_l;
      assign cand1_sum[LO +: N] = s_l;
      assign cand0_c[g]         = c_l;
      assign cand1_c[g]         = c_l;
    end else begin : g_upper
      logic [N:0] r0;
      logic [N:0] r1;
      logic [N:0] chosen;
      bk_group_adder #(.W(N)) u_add (
        .a(op_a[LO +: N]), .b(op_b[LO +: N]), .cin(1'b0),
        .s(r0[N-1:0]), .cout(r0[N])
      );
      add_one_conv #(.W(N+1)) u_inc (.x(r0), .y(r1));
      group_select #(.W(N+1)) u_sel (
        .cand0(r0), .cand1(r1), .sel(bnd_carry[g]), .pick(chosen)
      );
      assign sum[LO +: N]       = chosen[N-1:0];
      assign bnd_carry[g+1]     = chosen[N];
      assign cand0_sum[LO +: N] = r0[N-1:0];
      assign cand1_sum[LO +: N] = r1[N-1:0];
      assign cand0_c[g]         = r0[N];
      assign cand1_c[g]         = r1[N];
    end
  end

  assign carry_out = bnd_carry[NGROUPS];
endmodule

// File: rtl/sqrt_csel_adder_chk.sv
module sqrt_csel_adder_chk #(
  parameter int unsigned WIDTH   = 16,
  parameter int unsigned NGROUPS = 5,
  parameter bit [NGROUPS*8-1:0] GROUP_TBL = {8'd5, 8'd4, 8'd3, 8'd2, 8'd2}
) (
  input logic [WIDTH-1:0]   op_a,
  input logic [WIDTH-1:0]   op_b,
  input logic               carry_in,
  input logic [WIDTH-1:0]   sum,
  input logic               carry_out,
  input logic [NGROUPS:0]   bnd_carry,
  input logic [WIDTH-1:0]   cand0_sum,
  input logic [NGROUPS-1:0] cand0_c,
  input logic [WIDTH-1:0]   cand1_sum,
  input logic [NGROUPS-1:0] cand1_c
);
  import csel_pkg::*;
  localparam bit [255:0] TBL = 256'(GROUP_TBL);

  logic known;
  assign known = !$isunknown({op_a, op_b, carry_in, sum, carry_out,
                              bnd_carry, cand0_sum, cand0_c, cand1_sum, cand1_c});

  always_comb begin
    logic [63:0] a64, b64, full, m_lo, m_n, sa, sb, v0, v1, below;
    int unsigned lo, n;
    a64  = 64'(op_a);
    b64  = 64'(op_b);
    full = a64 + b64 + 64'(carry_in);
    if (known) begin
      assert_total_sum_R1: assert ({carry_out, sum} == full[WIDTH:0])
        else $error("R1 sum mismatch");
      for (int unsigned g = 1; g < NGROUPS; g++) begin
        lo    = grp_lo(TBL, g);
        n     = grp_width(TBL, g);
        m_lo  = (64'd1 << lo) - 64'd1;
        m_n   = (64'd1 << n) - 64'd1;
        below = (a64 & m_lo) + (b64 & m_lo) + 64'(carry_in);
        assert_boundary_carry_R3: assert (bnd_carry[g] == below[lo])
          else $error("R3 boundary carry wrong");
        sa = (a64 >> lo) & m_n;
        sb = (b64 >> lo) & m_n;
        v0 = {63'd0, cand0_c[g]} << n | ((64'(cand0_sum) >> lo) & m_n);
        v1 = {63'd0, cand1_c[g]} << n | ((64'(cand1_sum) >> lo) & m_n);
        assert_zero_cand_R5: assert (v0 == sa + sb)
          else $error("R5 carry-in-zero candidate wrong");
        assert_inc_cand_R4: assert (v1 == ((v0 + 64'd1) & ((m_n << 1) | 64'd1)))
          else $error("R4 increment candidate wrong");
      end
    end
  end
endmodule

bind sqrt_csel_adder sqrt_csel_adder_chk #(
  .WIDTH(WIDTH), .NGROUPS(NGROUPS), .GROUP_TBL(GROUP_TBL)
) u_chk (
  .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .sum(sum), .carry_out(carry_out),
  .bnd_carry(bnd_carry), .cand0_sum(cand0_sum), .cand0_c(cand0_c),
  .cand1_sum(cand1_sum), .cand1_c(cand1_c)
);

// File: tb/sqrt_csel_adder_test.sv
module sqrt_csel_adder_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] a16, b16, s16;
  logic        ci16, co16;
  logic [31:0] a32, b32, s32;
  logic        ci32, co32;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  sqrt_csel_adder uut (
    .op_a(a16), .op_b(b16), .carry_in(ci16), .sum(s16), .carry_out(co16)
  );

  sqrt_csel_adder #(
    .WIDTH(32), .NGROUPS(8),
    .GROUP_TBL({8'd3, 8'd7, 8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd2})
  ) uut32 (
    .op_a(a32), .op_b(b32), .carry_in(ci32), .sum(s32), .carry_out(co32)
  );

  // bitwise ripple reference, independent of the design structure
  function automatic logic [32:0] ref_add(logic [31:0] x, logic [31:0] y,
                                          logic c, int w);
    logic [32:0] r;
    logic cc;
    r  = '0;
    cc = c;
    for (int i = 0; i < w; i++) begin
      r[i] = x[i] ^ y[i] ^ cc;
      cc   = (x[i] & y[i]) | (cc & (x[i] ^ y[i]));
    end
    r[w] = cc;
    return r;
  endfunction

  task automatic chk16(string req, logic [15:0] x, logic [15:0] y, logic c);
    logic [16:0] exp;
    @(posedge clk);
    a16 = x; b16 = y; ci16 = c;
    #1;
    exp = ref_add(32'(x), 32'(y), c, 16)[16:0];
    n_cmp++;
    if ({co16, s16} !== exp) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h ci=%b got=%h exp=%h", req, x, y, c, {co16, s16}, exp);
    end
  endtask

  task automatic chk32(string req, logic [31:0] x, logic [31:0] y, logic c);
    logic [32:0] exp;
    @(posedge clk);
    a32 = x; b32 = y; ci32 = c;
    #1;
    exp = ref_add(x, y, c, 32);
    n_cmp++;
    if ({co32, s32} !== exp) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h ci=%b got=%h exp=%h", req, x, y, c, {co32, s32}, exp);
    end
  endtask

  // R6: raising carry_in adds exactly one
  task automatic chk_cin_step(logic [15:0] x, logic [15:0] y);
    logic [16:0] r0, r1;
    @(posedge clk);
    a16 = x; b16 = y; ci16 = 1'b0;
    #1 r0 = {co16, s16};
    ci16 = 1'b1;
    #1 r1 = {co16, s16};
    n_cmp++;
    if (r1 !== r0 + 17'd1) begin
      n_bad++;
      $display("FAIL R6 a=%h b=%h got=%h exp=%h", x, y, r1, r0 + 17'd1);
    end
  endtask

  initial begin
    int lo16 [5] = '{0, 2, 4, 7, 11};
    int lo32 [8] = '{0, 2, 4, 7, 11, 16, 22, 29};
    void'($urandom(32'h5eed_1234));
    a16 = '0; b16 = '0; ci16 = 1'b0;
    a32 = '0; b32 = '0; ci32 = 1'b0;

    chk16("R1 zeros", 16'h0000, 16'h0000, 1'b0);
    chk16("R1 ones", 16'hFFFF, 16'hFFFF, 1'b1);
    chk16("R1 ones+1", 16'hFFFF, 16'h0000, 1'b1);
    chk16("R1 alt", 16'hAAAA, 16'h5555, 1'b0);
    chk16("R1 alt cin", 16'hAAAA, 16'h5555, 1'b1);
    chk16("R1 alt2", 16'h5555, 16'h5555, 1'b1);
    chk32("R2 zeros", 32'h0, 32'h0, 1'b0);
    chk32("R2 ones", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    chk32("R2 alt", 32'hAAAA_AAAA, 32'h5555_5555, 1'b1);

    // R3/R4: carry crosses each group boundary, cin 0 and 1
    for (int g = 1; g < 5; g++) begin
      chk16("R3 boundary", 16'((1 << lo16[g]) - 1), 16'd1, 1'b0);
      chk16("R3 boundary cin", 16'((1 << lo16[g]) - 1), 16'd0, 1'b1);
      chk16("R4 group wrap", 16'hFFFF, 16'd0, 1'b1);
      chk16("R5 no carry", 16'((1 << lo16[g]) - 2), 16'd0, 1'b0);
    end
    for (int g = 1; g < 8; g++) begin
      chk32("R3 boundary32", 32'((64'd1 << lo32[g]) - 1), 32'd1, 1'b0);
      chk32("R3 boundary32 cin", 32'((64'd1 << lo32[g]) - 1), 32'd0, 1'b1);
    end

    for (int k = 0; k < 200; k++) chk_cin_step(16'($urandom), 16'($urandom));

    for (int k = 0; k < 100000; k++) begin
      logic [31:0] x, y;
      logic c;
      x = $urandom; y = $urandom; c = 1'(($urandom));
      chk16("R1 random", x[15:0], y[15:0], c);
      if (k < 40000) chk32("R2 random32", x, y, c);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule